// File: doc/BRIEF.md
# Compatibility Timer Status and Control Block

This block is the register side of a sound card's compatibility timer interface, seen from a byte-wide host bus. Four ports are selected by a two-bit select: a status/command port, a data port, an auxiliary port and the timer-control register. The block holds a command latch, a plain data byte, a timer data byte, a legacy status byte, a timer-control byte, a timer status byte and the timer bits of a shared interrupt-status byte. The countdown timers live elsewhere; they report each expiry through the two start-pulse inputs, and this block turns those pulses into status flags and interrupt requests.

Data-port writes are split by the latched command value into timer commands and plain data writes. Writes to the timer-control register clear flags whose enable bits are dropped, using fixed bit masks. The interrupt output is high while any bit of the interrupt-status byte is set. Reads are combinational and have no side effects.

Top module: `tsc_top`

## Requirements
- R1: A synchronous reset clears every held byte (command, plain data, timer data, legacy status, timer control, timer status, interrupt status) to 0x00 and drives the interrupt output low.
- R2: Port map: select 0 write loads the command latch; select 1 is the data port; select 2 write loads the legacy status byte; select 3 write loads timer control. Reads: select 0 returns timer status when timer-control bit 0 is 1 and the legacy status byte when it is 0; select 1 returns the plain data byte; select 2 returns the command latch; select 3 returns timer control.
- R3: A data-port write while the command latch equals 0x04 and timer-control bit 0 is 0 is a timer command: with data bit 7 set it clears timer-status bits 7:5, otherwise it loads the timer data byte. The plain data byte is left unchanged.
- R4: Any other data-port write loads the plain data byte; if timer-control bit 1 is 1 it also sets timer-status bit 0 and loads 0x10 into the interrupt-status byte.
- R5: A timer-control write with data bit 5 clear clears timer-status bits 4:3, with data bit 1 clear clears timer-status bit 0; if timer-status bits 4, 3 and 0 are then all 0, interrupt-status bit 4 is cleared.
- R6: A timer-control write with data bit 2 clear clears timer-status bit 2 and interrupt-status bit 2; with data bit 3 clear it clears timer-status bit 1 and interrupt-status bit 3.
- R7: A timer 1 start pulse ORs 0xC0 into timer status unless timer-data bit 6 is 1; if timer-control bit 2 is 1 it also sets timer-status bit 2 and interrupt-status bit 2.
- R8: A timer 2 start pulse ORs 0xA0 into timer status unless timer-data bit 5 is 1; if timer-control bit 3 is 1 it also sets timer-status bit 1 and interrupt-status bit 3.
- R9: The interrupt output is registered and, from the first clock edge after reset, equals the OR of all interrupt-status bits.
- R10: When a bus write and start pulses fall in the same cycle, the write's effects are applied first and the pulses then use the timer-control and timer-data values that the write leaves.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_sel | input | 2 | Port select for writes |
| bus_wdata | input | 8 | Write data |
| bus_rsel | input | 2 | Port select for reads |
| bus_rdata | output | 8 | Read data, combinational |
| t1_start | input | 1 | Timer 1 expiry pulse |
| t2_start | input | 1 | Timer 2 expiry pulse |
| irq_stat | output | 8 | Interrupt-status byte |
| irq | output | 1 | Interrupt request |

## Verification
The hardest path to reach is the timer-command branch of the data port, which needs the command latch at exactly 0x04 while timer-control bit 0 is 0; uniform random bytes would almost never line both up. The stimulus therefore writes 0x04 to the command port half the time and keeps timer-control bit 0 low most of the time, so timer commands, masked starts and flag clears interleave often. Directed steps also put a timer-control write and a start pulse in the same cycle to pin the ordering rule.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

  localparam int BYTE_W = 8;
  localparam int SEL_W  = 2;

  // port select codes
  localparam logic [SEL_W-1:0] SEL_CMD  = 2'd0;
  localparam logic [SEL_W-1:0] SEL_DATA = 2'd1;
  localparam logic [SEL_W-1:0] SEL_AUX  = 2'd2;
  localparam logic [SEL_W-1:0] SEL_CTL  = 2'd3;

  // timer-control bit positions
  localparam int CTL_VIEW   = 0;
  localparam int CTL_DIRQ   = 1;
  localparam int CTL_T1IE   = 2;
  localparam int CTL_T2IE   = 3;
  localparam int CTL_AUXIE  = 5;

  // timer-data mask bits
  localparam int TD_T1MASK  = 6;
  localparam int TD_T2MASK  = 5;

  localparam logic [BYTE_W-1:0] TMR_CMD_CODE = 8'h04;
  localparam logic [BYTE_W-1:0] DIRQ_VALUE   = 8'h10;
  localparam logic [BYTE_W-1:0] T1_FLAGS     = 8'hC0;
  localparam logic [BYTE_W-1:0] T2_FLAGS     = 8'hA0;
  localparam logic [BYTE_W-1:0] CMD_KEEP     = 8'h1F;

  typedef struct packed {
    logic [BYTE_W-1:0] ts;
    logic [BYTE_W-1:0] is;
  } flags_t;

  function automatic flags_t ctl_write_clear(flags_t f, logic [BYTE_W-1:0] c);
    flags_t r = f;
    if (!c[CTL_AUXIE]) r.ts[4:3] = 2'b00;
    if (!c[CTL_DIRQ])  r.ts[0]   = 1'b0;
    if (!(r.ts[4] | r.ts[3] | r.ts[0])) r.is[4] = 1'b0;
    if (!c[CTL_T1IE]) begin r.ts[2] = 1'b0; r.is[2] = 1'b0; end
    if (!c[CTL_T2IE]) begin r.ts[1] = 1'b0; r.is[3] = 1'b0; end
    return r;
  endfunction

  function automatic flags_t start_apply(flags_t f, logic [BYTE_W-1:0] td,
                                         logic [BYTE_W-1:0] c, logic s1, logic s2);
    flags_t r = f;
    if (s1) begin
      if (!td[TD_T1MASK]) r.ts = r.ts | T1_FLAGS;
      if (c[CTL_T1IE]) begin r.ts[2] = 1'b1; r.is[2] = 1'b1; end
    end
    if (s2) begin
      if (!td[TD_T2MASK]) r.ts = r.ts | T2_FLAGS;
      if (c[CTL_T2IE]) begin r.ts[1] = 1'b1; r.is[3] = 1'b1; end
    end
    return r;
  endfunction

  function automatic logic [BYTE_W-1:0] status_view(logic [BYTE_W-1:0] c,
                                                    logic [BYTE_W-1:0] ts,
                                                    logic [BYTE_W-1:0] legacy);
    return c[CTL_VIEW] ? ts : legacy;
  endfunction

endpackage

// File: rtl/tsc_port_decode.sv
module tsc_port_decode
  import tsc_pkg::*;
#(
  parameter logic [BYTE_W-1:0] CMD_CODE = TMR_CMD_CODE
) (
  input  logic              wr,
  input  logic [SEL_W-1:0]  sel,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [BYTE_W-1:0] cmd_q,
  input  logic [BYTE_W-1:0] ctl_q,
  output logic              cmd_wr,
  output logic              aux_wr,
  output logic              ctl_wr,
  output logic              tcmd_clr,
  output logic              tcmd_load,
  output logic              plain_wr
);
  logic data_wr;
  logic tcmd_mode;

  always_comb begin
    cmd_wr    = wr && (sel == SEL_CMD);
    data_wr   = wr && (sel == SEL_DATA);
    aux_wr    = wr && (sel == SEL_AUX);
    ctl_wr    = wr && (sel == SEL_CTL);
    tcmd_mode = (cmd_q == CMD_CODE) && !ctl_q[CTL_VIEW];
    tcmd_clr  = data_wr && tcmd_mode && wdata[BYTE_W-1];
    tcmd_load = data_wr && tcmd_mode && !wdata[BYTE_W-1];
    plain_wr  = data_wr && !tcmd_mode;
  end
endmodule

// File: rtl/tsc_flag_engine.sv
module tsc_flag_engine
  import tsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tcmd_clr,
  input  logic              plain_wr,
  input  logic              ctl_wr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [BYTE_W-1:0] ctl_q,
  input  logic [BYTE_W-1:0] ctl_nxt,
  input  logic [BYTE_W-1:0] td_nxt,
  input  logic              t1_start,
  input  logic              t2_start,
  output logic [BYTE_W-1:0] ts_q,
  output logic [BYTE_W-1:0] is_q,
  output logic              irq_q
);
  flags_t f_now, f_wr, f_nxt;
  logic   ev_plain_irq;

  assign ev_plain_irq = plain_wr && ctl_q[CTL_DIRQ];

  always_comb begin
    f_now = '{ts: ts_q, is: is_q};
    f_wr  = f_now;
    if (tcmd_clr) f_wr.ts = f_wr.ts & CMD_KEEP;
    if (ev_plain_irq) begin
      f_wr.ts[0] = 1'b1;
      f_wr.is    = DIRQ_VALUE;
    end
    if (ctl_wr) f_wr = ctl_write_clear(f_wr, wdata);
    f_nxt = start_apply(f_wr, td_nxt, ctl_nxt, t1_start, t2_start);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ts_q  <= '0;
      is_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      ts_q  <= f_nxt.ts;
      is_q  <= f_nxt.is;
      irq_q <= |f_nxt.is;
    end
  end

  // R3: a timer command with bit 7 clears the top three status bits
  a_r3_cmd_clears_top: assert property (@(posedge clk) disable iff (rst)
    tcmd_clr && !t1_start && !t2_start |=> ts_q[7:5] == 3'b000);

  // R4: enabled plain write raises status bit 0 and interrupt bit 4
  a_r4_plain_irq: assert property (@(posedge clk) disable iff (rst)
    plain_wr && ctl_q[CTL_DIRQ] |=> ts_q[0] && is_q[4]);

  // R6: dropping the timer 1 enable clears its flags when no pulse competes
  a_r6_t1_disable: assert property (@(posedge clk) disable iff (rst)
    ctl_wr && !wdata[CTL_T1IE] && !t1_start |=> !ts_q[2] && !is_q[2]);

  // R7: an enabled timer 1 start sets its non-maskable flags
  a_r7_t1_set: assert property (@(posedge clk) disable iff (rst)
    t1_start && ctl_nxt[CTL_T1IE] |=> ts_q[2] && is_q[2]);

  // R8: an enabled timer 2 start sets its non-maskable flags
  a_r8_t2_set: assert property (@(posedge clk) disable iff (rst)
    t2_start && ctl_nxt[CTL_T2IE] |=> ts_q[1] && is_q[3]);

  // R8: an unmasked timer 2 start sets bits 7 and 5
  a_r8_t2_maskable: assert property (@(posedge clk) disable iff (rst)
    t2_start && !td_nxt[TD_T2MASK] |=> ts_q[7] && ts_q[5]);

  // R9: the interrupt line tracks the status byte
  a_r9_irq_level: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq_q == (|is_q));
endmodule

// File: rtl/tsc_read_mux.sv
module tsc_read_mux
  import tsc_pkg::*;
(
  input  logic [SEL_W-1:0]  rsel,
  input  logic [BYTE_W-1:0] ctl_q,
  input  logic [BYTE_W-1:0] ts_q,
  input  logic [BYTE_W-1:0] legacy_q,
  input  logic [BYTE_W-1:0] pdata_q,
  input  logic [BYTE_W-1:0] cmd_q,
  output logic [BYTE_W-1:0] rdata
);
  always_comb begin
    unique case (rsel)
      SEL_CMD:  rdata = status_view(ctl_q, ts_q, legacy_q);
      SEL_DATA: rdata = pdata_q;
      SEL_AUX:  rdata = cmd_q;
      default:  rdata = ctl_q;
    endcase
  end
endmodule

// File: rtl/tsc_top.sv
module tsc_top
  import tsc_pkg::*;
#(
  parameter logic [BYTE_W-1:0] CMD_CODE = TMR_CMD_CODE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [SEL_W-1:0]  bus_sel,
  input  logic [BYTE_W-1:0] bus_wdata,
  input  logic [SEL_W-1:0]  bus_rsel,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              t1_start,
  input  logic              t2_start,
  output logic [BYTE_W-1:0] irq_stat,
  output logic              irq
);
  logic [BYTE_W-1:0] cmd_q, pdata_q, td_q, legacy_q, ctl_q;
  logic [BYTE_W-1:0] ctl_nxt, td_nxt, ts_q, is_q;
  logic cmd_wr, aux_wr, ctl_wr, tcmd_clr, tcmd_load, plain_wr;

  tsc_port_decode #(.CMD_CODE(CMD_CODE)) u_dec (
    .wr(bus_wr), .sel(bus_sel), .wdata(bus_wdata),
    .cmd_q(cmd_q), .ctl_q(ctl_q),
    .cmd_wr(cmd_wr), .aux_wr(aux_wr), .ctl_wr(ctl_wr),
    .tcmd_clr(tcmd_clr), .tcmd_load(tcmd_load), .plain_wr(plain_wr)
  );

  assign ctl_nxt = ctl_wr    ? bus_wdata : ctl_q;
  assign td_nxt  = tcmd_load ? bus_wdata : td_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q    <= '0;
      pdata_q  <= '0;
      td_q     <= '0;
      legacy_q <= '0;
      ctl_q    <= '0;
    end else begin
      if (cmd_wr)   cmd_q    <= bus_wdata;
      if (plain_wr) pdata_q  <= bus_wdata;
      if (aux_wr)   legacy_q <= bus_wdata;
      td_q  <= td_nxt;
      ctl_q <= ctl_nxt;
    end
  end

  tsc_flag_engine u_flags (
    .clk(clk), .rst(rst),
    .tcmd_clr(tcmd_clr), .plain_wr(plain_wr), .ctl_wr(ctl_wr),
    .wdata(bus_wdata), .ctl_q(ctl_q), .ctl_nxt(ctl_nxt), .td_nxt(td_nxt),
    .t1_start(t1_start), .t2_start(t2_start),
    .ts_q(ts_q), .is_q(is_q), .irq_q(irq)
  );

  tsc_read_mux u_rd (
    .rsel(bus_rsel), .ctl_q(ctl_q), .ts_q(ts_q), .legacy_q(legacy_q),
    .pdata_q(pdata_q), .cmd_q(cmd_q), .rdata(bus_rdata)
  );

  assign irq_stat = is_q;

  // R1: the cycle after reset everything reads back as zero
  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (is_q == '0) && !irq && (ctl_q == '0) && (ts_q == '0));

  // R3: a timer command never disturbs the plain data byte
  a_r3_plain_kept: assert property (@(posedge clk) disable iff (rst)
    (tcmd_clr || tcmd_load) |=> $stable(pdata_q));
endmodule

// File: tb/test_tsc_top.sv
module test_tsc_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_sel = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [1:0] bus_rsel = 2'd0;
  logic [7:0] bus_rdata;
  logic       t1_start = 1'b0;
  logic       t2_start = 1'b0;
  logic [7:0] irq_stat;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // reference state
  logic [7:0] m_cmd, m_pd, m_td, m_leg, m_ctl, m_ts, m_is;

  always #(CLK_PERIOD/2) clk = ~clk;

  tsc_top i_tsc_top (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rsel(bus_rsel), .bus_rdata(bus_rdata),
    .t1_start(t1_start), .t2_start(t2_start), .irq_stat(irq_stat), .irq(irq)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_read(logic [1:0] s);
    if (s == 2'd0) return (m_ctl & 8'h01) != 0 ? m_ts : m_leg;
    if (s == 2'd1) return m_pd;
    if (s == 2'd2) return m_cmd;
    return m_ctl;
  endfunction

  task automatic model_reset();
    m_cmd = 0; m_pd = 0; m_td = 0; m_leg = 0; m_ctl = 0; m_ts = 0; m_is = 0;
  endtask

  task automatic model_step(bit wr, logic [1:0] s, logic [7:0] d, bit p1, bit p2);
    if (wr) begin
      if (s == 2'd0) m_cmd = d;
      else if (s == 2'd2) m_leg = d;
      else if (s == 2'd1) begin
        if (m_cmd == 8'h04 && m_ctl[0] == 1'b0) begin
          if (d >= 8'h80) m_ts = m_ts & ~8'hE0;
          else m_td = d;
        end else begin
          m_pd = d;
          if (m_ctl[1]) begin m_ts = m_ts | 8'h01; m_is = 8'h10; end
        end
      end else begin
        m_ctl = d;
        if (d[5] == 1'b0) m_ts = m_ts & ~8'h18;
        if (d[1] == 1'b0) m_ts = m_ts & ~8'h01;
        if ((m_ts & 8'h19) == 8'h00) m_is = m_is & ~8'h10;
        if (d[2] == 1'b0) begin m_ts = m_ts & ~8'h04; m_is = m_is & ~8'h04; end
        if (d[3] == 1'b0) begin m_ts = m_ts & ~8'h02; m_is = m_is & ~8'h08; end
      end
    end
    if (p1) begin
      if (m_td[6] == 1'b0) m_ts = m_ts | 8'hC0;
      if (m_ctl[2]) begin m_ts = m_ts | 8'h04; m_is = m_is | 8'h04; end
    end
    if (p2) begin
      if (m_td[5] == 1'b0) m_ts = m_ts | 8'hA0;
      if (m_ctl[3]) begin m_ts = m_ts | 8'h02; m_is = m_is | 8'h08; end
    end
  endtask

  // called at a negative edge; returns at the next negative edge
  task automatic step(bit wr, logic [1:0] s, logic [7:0] d, bit p1, bit p2);
    bus_wr = wr; bus_sel = s; bus_wdata = d; t1_start = p1; t2_start = p2;
    @(posedge clk);
    model_step(wr, s, d, p1, p2);
    @(negedge clk);
    bus_wr = 1'b0; t1_start = 1'b0; t2_start = 1'b0;
  endtask

  task automatic rd(logic [1:0] s, output logic [7:0] v);
    bus_rsel = s;
    #1;
    v = bus_rdata;
  endtask

  task automatic check_all(string ctx);
    logic [7:0] v;
    rd(2'd0, v); chk({"R2 status view ", ctx}, v, ref_read(2'd0));
    rd(2'd1, v); chk({"R4 plain data ", ctx}, v, ref_read(2'd1));
    rd(2'd2, v); chk({"R2 command ", ctx}, v, ref_read(2'd2));
    rd(2'd3, v); chk({"R5 control ", ctx}, v, ref_read(2'd3));
    chk({"R6 irq_stat ", ctx}, irq_stat, m_is);
    chk({"R9 irq ", ctx}, {7'd0, irq}, {7'd0, (m_is != 0)});
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v;
    void'($urandom(32'h0000_7A11));
    model_reset();
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check_all("r1_ after reset");
    chk("R1 irq low after reset", {7'd0, irq}, 8'h00);

    // R4 plain write with data interrupt enabled
    step(1, 2'd3, 8'h02, 0, 0);
    step(1, 2'd1, 8'h5A, 0, 0);
    chk("R4 irq_stat loaded", irq_stat, 8'h10);
    chk("R9 irq raised", {7'd0, irq}, 8'h01);
    check_all("r4_");

    // R2 status view selection
    step(1, 2'd2, 8'h3C, 0, 0);
    rd(2'd0, v); chk("R2 legacy view", v, 8'h3C);
    step(1, 2'd3, 8'h03, 0, 0);
    rd(2'd0, v); chk("R2 timer view", v, 8'h01);

    // R5 dropping the data interrupt enable
    step(1, 2'd3, 8'h00, 0, 0);
    chk("R5 irq bit4 cleared", irq_stat, 8'h00);
    check_all("r5_");

    // R7 and R8 unmasked starts
    step(1, 2'd3, 8'h0C, 0, 0);
    step(0, 2'd0, 8'h00, 1, 0);
    chk("R7 irq bit2", irq_stat, 8'h04);
    step(0, 2'd0, 8'h00, 0, 1);
    chk("R8 irq bit3", irq_stat, 8'h0C);
    step(1, 2'd3, 8'h0D, 0, 0);
    rd(2'd0, v); chk("R7 R8 timer status", v, 8'hE6);
    check_all("r8_");

    // R3 timer commands
    step(1, 2'd3, 8'h0C, 0, 0);
    step(1, 2'd0, 8'h04, 0, 0);
    step(1, 2'd1, 8'h80, 0, 0);
    check_all("r3_ clear");
    step(1, 2'd1, 8'h60, 0, 0);
    rd(2'd1, v); chk("R3 plain untouched", v, 8'h5A);
    step(0, 2'd0, 8'h00, 1, 1);
    check_all("r7_ masked starts");
    step(1, 2'd3, 8'h0D, 0, 0);
    rd(2'd0, v); chk("R3 masked status", v, 8'h06);
    step(1, 2'd1, 8'h11, 0, 0);
    rd(2'd1, v); chk("R3 view bit forces plain", v, 8'h11);

    // R6 clearing the non-maskable flags
    step(1, 2'd3, 8'h01, 0, 0);
    chk("R6 irq cleared", irq_stat, 8'h00);
    check_all("r6_");

    // R10 same-cycle control write and start
    step(1, 2'd3, 8'h04, 1, 0);
    chk("R10 new enable used", irq_stat, 8'h04);
    check_all("r10_");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] s;
      logic [7:0] d;
      bit w, p1, p2;
      w  = ($urandom % 4) != 0;
      s  = 2'($urandom % 4);
      d  = 8'($urandom);
      if (s == 2'd0 && ($urandom % 2) == 0) d = 8'h04;
      if (s == 2'd3 && ($urandom % 4) != 0) d[0] = 1'b0;
      p1 = ($urandom % 6) == 0;
      p2 = ($urandom % 6) == 0;
      step(w, s, d, p1, p2);
      check_all("r10_ random");
    end

    // R1 reset from a busy state
    step(1, 2'd3, 8'h0E, 1, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    check_all("r1_ second reset");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule